// File: doc/BRIEF.md
# Sectioned Pin Bank Controller with Interrupt Latching

The block is a memory-mapped general-purpose pin controller. Its pins are split into equal sections (by default four sections of eight pins, 32 pins in all), and each section owns a 64-byte register window. Within a window, software sets pin direction and output level, reads the synchronised pin levels, and manages interrupts. Interrupt management covers a latched status, per-pin masking through separate set and clear ports, and a per-pin choice between edge and level behaviour. A plain register bus with address, write enable, write data and combinational read data reaches every window.

Pin inputs pass through a two-flop synchroniser before they are used. Outputs and output enables go straight to the pads. All masked status bits are ORed onto one interrupt line.

Top module: `pin_bank_ctrl`

## Requirements
- R1: The upper address bits `bus_addr[7:6]` select the section and `bus_addr[5:0]` selects the register. Pin n is bit n%8 of section n/8, so pin 10 is bit 2 of the window at 0x40. Offsets that are not listed read 0, and writes to them change nothing.
- R2: Offset 0x10 is the direction register, reset 0xFF, where 1 means input. `pin_oe[n]` is 1 exactly when pin n's direction bit is 0.
- R3: Offset 0x14 is the output register, reset 0, and it drives `pin_out`.
- R4: Offset 0x18 reads the pin levels two clock edges after they are applied. Writes to it have no effect.
- R5: On an edge-type pin, a rising edge of the synchronised input sets the raw status bit at offset 0x04 on the third clock edge after the pin rises. The bit then stays set.
- R6: Writing 1s to offset 0x04 clears those raw status bits. A rising edge that lands in the same cycle as the clear wins, and the bit stays 1.
- R7: Offset 0x20 holds the interrupt type (1 = level). It resets to 0, and a write sets the bits written as 1. On a level pin, the status bit follows the synchronised input, and a clear write does not drop it while the input is high.
- R8: Offset 0x08 reads the mask and resets to 0xFF. Writing 1s there masks those pins. Writing 1s to offset 0x0C unmasks them, and offset 0x0C reads 0.
- R9: Offset 0x00 reads raw status AND NOT mask. Writes to it have no effect.
- R10: `irq` is 1 exactly when some pin in any section has a masked-status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address: section in [7:6], offset in [5:0] |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data (low 8 bits used) |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The most delicate overlap is between a status-clear write and a new rising edge on the same pin. A second overlap is between a clear write and a level pin whose input is still high. The bench raises a pin and then writes the clear on exactly the cycle the synchronised edge arrives, and it expects the status to remain 1. It also holds a level pin high across a clear write and expects the status to survive. A cycle-accurate bench model covers both cases, and random traffic mixes writes, pin changes and reads so that they collide freely.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    localparam int DEF_SECTIONS  = 4;
    localparam int DEF_SECT_PINS = 8;
    localparam int OFS_W         = 6;

    typedef enum logic [OFS_W-1:0] {
        OFS_MSTAT = 6'h00,
        OFS_STAT  = 6'h04,
        OFS_MSET  = 6'h08,
        OFS_MCLR  = 6'h0C,
        OFS_DIR   = 6'h10,
        OFS_OUT   = 6'h14,
        OFS_IN    = 6'h18,
        OFS_LVL   = 6'h20
    } reg_ofs_e;

    typedef struct packed {
        logic stat_clr;
        logic mask_set;
        logic mask_clr;
        logic dir_wr;
        logic out_wr;
        logic lvl_set;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(logic we, logic [OFS_W-1:0] ofs);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (ofs)
                OFS_STAT: s.stat_clr = 1'b1;
                OFS_MSET: s.mask_set = 1'b1;
                OFS_MCLR: s.mask_clr = 1'b1;
                OFS_DIR:  s.dir_wr   = 1'b1;
                OFS_OUT:  s.out_wr   = 1'b1;
                OFS_LVL:  s.lvl_set  = 1'b1;
                default:  s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced,
    output logic [W-1:0] synced_d
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            synced   <= '0;
            synced_d <= '0;
        end else begin
            stage1   <= raw;
            synced   <= stage1;
            synced_d <= synced;
        end
    end
endmodule

// File: rtl/pin_section.sv
module pin_section
    import pin_bank_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_strobe_t           strb,
    input  logic [PINS-1:0]      wdata,
    input  logic [OFS_W-1:0]     rd_ofs,
    input  logic [PINS-1:0]      in_s,
    input  logic [PINS-1:0]      in_d,
    output logic [PINS-1:0]      dir,
    output logic [PINS-1:0]      out,
    output logic [PINS-1:0]      mask,
    output logic [PINS-1:0]      lvl,
    output logic [PINS-1:0]      stat,
    output logic [PINS-1:0]      rd
);
    logic [PINS-1:0] rise;
    logic [PINS-1:0] clr_bits;

    assign rise     = in_s & ~in_d;
    assign clr_bits = strb.stat_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir  <= '1;
            out  <= '0;
            mask <= '1;
            lvl  <= '0;
        end else begin
            if (strb.dir_wr)   dir  <= wdata;
            if (strb.out_wr)   out  <= wdata;
            if (strb.mask_set) mask <= mask | wdata;
            if (strb.mask_clr) mask <= mask & ~wdata;
            if (strb.lvl_set)  lvl  <= lvl | wdata;
        end
    end

    for (genvar b = 0; b < PINS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                stat[b] <= 1'b0;
            else if (lvl[b])
                stat[b] <= in_s[b];
            else
                stat[b] <= (stat[b] & ~clr_bits[b]) | rise[b];
        end
    end

    always_comb begin
        case (rd_ofs)
            OFS_MSTAT: rd = stat & ~mask;
            OFS_STAT:  rd = stat;
            OFS_MSET:  rd = mask;
            OFS_DIR:   rd = dir;
            OFS_OUT:   rd = out;
            OFS_IN:    rd = in_s;
            OFS_LVL:   rd = lvl;
            default:   rd = '0;
        endcase
    end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pin_bank_pkg::*;
#(
    parameter int NUM_SECT  = DEF_SECTIONS,
    parameter int SECT_PINS = DEF_SECT_PINS,
    parameter int DATA_W    = 32,
    localparam int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
    localparam int ADDR_W   = OFS_W + SECT_W,
    localparam int NPINS    = NUM_SECT * SECT_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [SECT_W-1:0] sect;
    logic [OFS_W-1:0]  ofs;
    logic [NPINS-1:0]  in_s, in_d;
    logic [NPINS-1:0]  dir_v, mask_v, lvl_v, stat_v;
    logic [SECT_PINS-1:0] rd_arr [NUM_SECT];

    assign sect = bus_addr[ADDR_W-1:OFS_W];
    assign ofs  = bus_addr[OFS_W-1:0];

    pin_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (pin_in),
        .synced   (in_s),
        .synced_d (in_d)
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        localparam int LO = s * SECT_PINS;
        wr_strobe_t strb;
        assign strb = decode_write(bus_we && (sect == SECT_W'(s)), ofs);

        pin_section #(.PINS(SECT_PINS)) u_sect (
            .clk    (clk),
            .rst    (rst),
            .strb   (strb),
            .wdata  (bus_wdata[SECT_PINS-1:0]),
            .rd_ofs (ofs),
            .in_s   (in_s[LO +: SECT_PINS]),
            .in_d   (in_d[LO +: SECT_PINS]),
            .dir    (dir_v[LO +: SECT_PINS]),
            .out    (pin_out[LO +: SECT_PINS]),
            .mask   (mask_v[LO +: SECT_PINS]),
            .lvl    (lvl_v[LO +: SECT_PINS]),
            .stat   (stat_v[LO +: SECT_PINS]),
            .rd     (rd_arr[s])
        );
    end

    assign pin_oe = ~dir_v;
    assign irq    = |(stat_v & ~mask_v);

    always_comb begin
        bus_rdata = '0;
        if (32'(sect) < NUM_SECT)
            bus_rdata[SECT_PINS-1:0] = rd_arr[sect];
    end
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
    parameter int NPINS     = 32,
    parameter int SECT_PINS = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [NPINS-1:0]  mask_v,
    input logic [NPINS-1:0]  lvl_v,
    input logic [NPINS-1:0]  stat_v,
    input logic [NPINS-1:0]  in_s
);
    logic [NPINS-1:0] wr_vec;
    logic [5:0]       ofs;
    assign ofs    = bus_addr[5:0];
    assign wr_vec = NPINS'(bus_wdata[SECT_PINS-1:0]) << (SECT_PINS * int'(bus_addr[ADDR_W-1:6]));

    // R8: mask set write takes effect
    a_r8_mask_set: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ofs == 6'h08) |=> ((mask_v & $past(wr_vec)) == $past(wr_vec)));

    // R8: unmask write takes effect
    a_r8_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ofs == 6'h0C) |=> ((mask_v & $past(wr_vec)) == '0));

    // R10: fully masked bank never interrupts
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask_v) |-> !irq);

    // R7: level pins track the synchronised input one cycle later
    a_r7_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_v & $past(lvl_v)) == ($past(in_s) & $past(lvl_v))));

    // R5: edge status stays set unless cleared
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_v & ~((bus_we && ofs == 6'h04) ? wr_vec : '0)) & ~lvl_v & ~stat_v) == '0));

    // R7: level type bits never drop without reset
    a_r7_level_only_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(lvl_v) & ~lvl_v) == '0));
endmodule

bind pin_bank_ctrl pin_bank_chk #(
    .NPINS(NPINS), .SECT_PINS(SECT_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .irq(irq), .mask_v(mask_v), .lvl_v(lvl_v),
    .stat_v(stat_v), .in_s(in_s)
);

// File: tb/test_pin_bank_ctrl.sv
module test_pin_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    pin_bank_ctrl i_pin_bank_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // requirement-level model of the bank
    logic [31:0] m_dir, m_out, m_mask, m_lvl, m_stat, m_s1, m_s2, m_sd;

    function automatic logic [31:0] spread(logic [7:0] a, logic [31:0] d);
        return {24'b0, d[7:0]} << (8 * a[7:6]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir <= '1; m_out <= '0; m_mask <= '1; m_lvl <= '0;
            m_stat <= '0; m_s1 <= '0; m_s2 <= '0; m_sd <= '0;
        end else begin
            logic [31:0] v, clr;
            v   = spread(bus_addr, bus_wdata);
            clr = (bus_we && bus_addr[5:0] == 6'h04) ? v : '0;
            m_s1 <= pin_in; m_s2 <= m_s1; m_sd <= m_s2;
            m_stat <= (m_lvl & m_s2) | (~m_lvl & ((m_stat & ~clr) | (m_s2 & ~m_sd)));
            if (bus_we) begin
                case (bus_addr[5:0])
                    6'h08: m_mask <= m_mask | v;
                    6'h0C: m_mask <= m_mask & ~v;
                    6'h10: m_dir  <= (m_dir & ~(32'hFF << (8*bus_addr[7:6]))) | v;
                    6'h14: m_out  <= (m_out & ~(32'hFF << (8*bus_addr[7:6]))) | v;
                    6'h20: m_lvl  <= m_lvl | v;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [31:0] full;
        case (a[5:0])
            6'h00: full = m_stat & ~m_mask;
            6'h04: full = m_stat;
            6'h08: full = m_mask;
            6'h10: full = m_dir;
            6'h14: full = m_out;
            6'h18: full = m_s2;
            6'h20: full = m_lvl;
            default: full = '0;
        endcase
        return (full >> (8 * a[7:6])) & 32'hFF;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cyc(logic [7:0] a, logic we, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        cyc(a, 1'b0, '0);
        #5;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, exp_read(a));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, '0);
    endtask

    bit done = 0;
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [5:0] ofs_set [8] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20};
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        #5;
        check("R2 reset oe", pin_oe, 32'h0);
        check("R3 reset out", pin_out, 32'h0);
        check("R10 reset irq", {31'b0, irq}, 32'h0);
        rd_chk("R8 reset mask", 8'hC8, 32'hFF);
        rd_chk("R2 reset dir", 8'h50, 32'hFF);
        rd_chk("R7 reset lvl", 8'h20, 32'h0);

        // R1/R2/R3: pin 10 = section 1 bit 2
        cyc(8'h50, 1'b1, 32'hFB);
        cyc(8'h54, 1'b1, 32'h04);
        idle(1); #5;
        check("R2 oe pin10", pin_oe, 32'h0000_0400);
        check("R3 out pin10", pin_out, 32'h0000_0400);
        // R1 unused offset write ignored, read zero
        cyc(8'h5C, 1'b1, 32'hFF);
        rd_chk("R1 unused", 8'h5C, 32'h0);
        rd_chk("R1 out unchanged", 8'h54, 32'h04);
        // R4 input register, write ignored
        cyc(8'h98, 1'b1, 32'hFF);
        @(negedge clk); pin_in = 32'h00A5_0000;
        idle(1);
        rd_chk("R4 input two edges", 8'h98, 32'hA5);

        // R5/R6 edge on pin 0 with clear landing on the edge cycle
        cyc(8'h0C, 1'b1, 32'h01);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(3);
        rd_chk("R5 edge latched", 8'h04, 32'h01);
        check("R10 irq on", {31'b0, irq}, 32'h1);
        rd_chk("R9 masked stat", 8'h00, 32'h01);
        pin_in[0] = 1'b0;
        idle(3);
        rd_chk("R5 sticky", 8'h04, 32'h01);
        cyc(8'h04, 1'b1, 32'h01);
        rd_chk("R6 cleared", 8'h04, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1; bus_we = 1'b0;
        @(negedge clk);
        cyc(8'h04, 1'b1, 32'h01);
        rd_chk("R6 edge wins over clear", 8'h04, 32'h01);
        cyc(8'h08, 1'b1, 32'h01);
        idle(1); #5;
        check("R8 remask irq", {31'b0, irq}, 32'h0);
        rd_chk("R8 unmask port reads 0", 8'h0C, 32'h0);

        // R7 level pin 9 held high survives clear
        cyc(8'h60, 1'b1, 32'h02);
        @(negedge clk); pin_in[9] = 1'b1;
        idle(4);
        cyc(8'h44, 1'b1, 32'h02);
        rd_chk("R7 level kept high", 8'h44, 32'h02);
        pin_in[9] = 1'b0;
        idle(3);
        rd_chk("R7 level follows low", 8'h44, 32'h0);

        // random traffic
        for (int it = 0; it < 1500; it++) begin
            logic [7:0] a;
            a = {2'($urandom), ofs_set[$urandom % 8]};
            if ($urandom % 4 == 0) a[5:0] = 6'($urandom) & 6'h3C;
            @(negedge clk);
            if ($urandom % 3 == 0) pin_in = pin_in ^ (32'b1 << ($urandom % 32));
            bus_addr = a;
            bus_we = ($urandom % 3 == 0);
            bus_wdata = $urandom;
            #5;
            check("R1 random read", bus_rdata, exp_read(a));
            check("R10 random irq", {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
            check("R2 random oe", pin_oe, ~m_dir);
            check("R3 random out", pin_out, m_out);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule